// File: doc/BRIEF.md
# Two-Thread Performance Counter Bank

This block gives each of a core's two hardware threads its own private set of event counters: four programmable general counters and three fixed-function counters per thread. Every general counter has a 32-bit event-select register that picks one of the per-thread event lines, chooses which privilege levels may count, enables the counter, and carries an any-thread control. With the any-thread control clear, a counter sees only the owning thread's events. With it set, the counter also takes qualifying events from the sibling thread. The privilege filter is always checked against the level of the thread on which the event happened.

Software reaches the counters through a single register port. Each access carries a thread ID, so one thread can never see or modify the other thread's register set. Counter index 0 on thread 0 and counter index 0 on thread 1 are fully separate and can count different events at the same time. When a counter wraps, it raises a sticky overflow flag that belongs to its own thread. Each thread has a write-one-to-clear register for its flags.

Top module: `smt_perf_counters`

## Requirements
- R1: After reset, every event-select, counter, fixed-control and overflow bit of both threads reads as zero, and `ovf_o` is zero.
- R2: A general counter with enable (bit 22) set and any-thread (bit 21) clear adds 1 at a clock edge if its owning thread's event line with index equal to the event code (bits 7:0) was high in that cycle and the privilege matched. Events on the sibling thread have no effect on it.
- R3: With any-thread set, the counter also counts the sibling thread's qualifying event on the same line, and adds 2 in a cycle in which both threads qualify.
- R4: Privilege level 0 needs the OS bit (bit 17) and any other level needs the USR bit (bit 16). Each contributing thread is judged by its own level.
- R5: A general counter with the enable bit clear, or with an event code not below the number of event lines (8), never counts.
- R6: A register access reaches only the register set of the thread given by `reg_tid`. Counters with the same index on the two threads count independently.
- R7: Fixed counter j counts fixed input j (0 instructions retired, 1 core cycles, 2 reference cycles). Its control is field bits [4j+3:4j] of the fixed-control register: bit 0 OS, bit 1 USR, bit 2 any-thread, bit 3 reserved (stored, no effect). There is no separate enable.
- R8: A write to a counter in the same cycle as an increment loads the written value, and the increment is lost.
- R9: A counter that wraps past all ones to zero sets its thread's overflow flag (general counter i at bit i, fixed counter j at bit 4+j). The flag stays set until it is cleared. A counter that is being written does not set a flag.
- R10: A write to the overflow-clear address clears the flag bits that are 1 in the write data, for the writing thread only. A wrap in the same cycle keeps its bit set.
- R11: Reads are combinational. Address map: 0-3 event selects, 4-7 general counters, 8-10 fixed counters, 11 fixed control, 12 overflow flags, 13 overflow clear (reads 0), 14-15 read 0. Narrow registers read zero-extended, and writes to them keep only their low bits (32 for selects, 12 for fixed control).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 2x8 | Per-thread event lines for the current cycle |
| priv_i | input | 2x2 | Per-thread privilege level (0 = OS) |
| fix_i | input | 2x3 | Per-thread fixed inputs: instr retired, core cycle, ref cycle |
| reg_we | input | 1 | Register write strobe |
| reg_tid | input | 1 | Thread that owns the access |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 48 | Write data |
| reg_rdata | output | 48 | Read data for the addressed register of `reg_tid` |
| ovf_o | output | 2x7 | Sticky overflow flags, per thread |

## Verification
An event seen during a cycle changes the counter at the next rising edge. A register write also takes effect at that edge, so both are visible on `reg_rdata` and `ovf_o` in the half cycle that follows, with no further delay. A changed event select or fixed control first steers counting one cycle after it is written. The bench applies stimulus at falling edges and moves its reference model forward right after each rising edge, using the values that edge sampled. It reads back 2 ns after a falling edge, while the event inputs are held at zero so that nothing moves under the read.

// File: rtl/smt_pmu_pkg.sv
package smt_pmu_pkg;
  localparam int SEL_W       = 32;
  localparam int SEL_USR_BIT = 16;
  localparam int SEL_OS_BIT  = 17;
  localparam int SEL_ANY_BIT = 21;
  localparam int SEL_EN_BIT  = 22;
  localparam int FX_FIELD_W  = 4;
  localparam int FX_OS_BIT   = 0;
  localparam int FX_USR_BIT  = 1;
  localparam int FX_ANY_BIT  = 2;

  typedef logic [1:0] priv_t;

  // level 0 is supervisor, everything else is user
  function automatic logic priv_match(input priv_t lvl, input logic os_en, input logic usr_en);
    return (lvl == 2'd0) ? os_en : usr_en;
  endfunction

  // step size: own hit plus sibling hit when cross-thread counting is on
  function automatic logic [1:0] merge_hits(input logic own_q, input logic sib_q, input logic any_en);
    return {1'b0, own_q} + {1'b0, any_en & sib_q};
  endfunction
endpackage

// File: rtl/smt_pmu_gate.sv
module smt_pmu_gate
  import smt_pmu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       own_raw,
  input  logic       sib_raw,
  input  priv_t      own_lvl,
  input  priv_t      sib_lvl,
  input  logic       os_en,
  input  logic       usr_en,
  input  logic       any_en,
  input  logic       cnt_en,
  output logic [1:0] inc_o
);
  logic own_q;
  logic sib_q;

  assign own_q = cnt_en & own_raw & priv_match(own_lvl, os_en, usr_en);
  assign sib_q = cnt_en & sib_raw & priv_match(sib_lvl, os_en, usr_en);
  assign inc_o = merge_hits(own_q, sib_q, any_en);

  assert_single_thread_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !any_en |-> inc_o <= 2'd1);
  assert_double_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    inc_o == 2'd2 |-> (any_en && own_raw && sib_raw));
  assert_no_priv_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!os_en && !usr_en) |-> inc_o == 2'd0);
  assert_disabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |-> inc_o == 2'd0);
endmodule

// File: rtl/smt_pmu_counter.sv
module smt_pmu_counter #(
  parameter int CNT_W = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       inc,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_val,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [CNT_W:0] sum;

  assign sum    = {1'b0, cnt_o} + {{(CNT_W-1){1'b0}}, inc};
  assign wrap_o = !wr_en && sum[CNT_W];

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt_o <= '0;
    else if (wr_en) cnt_o <= wr_val;
    else            cnt_o <= sum[CNT_W-1:0];
  end

  assert_write_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> cnt_o == $past(wr_val));
  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && inc == 2'd0) |=> $stable(cnt_o));
  assert_wrap_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |=> cnt_o < CNT_W'(2));
endmodule

// File: rtl/smt_pmu_thread_regs.sv
module smt_pmu_thread_regs
  import smt_pmu_pkg::*;
#(
  parameter int NUM_GP  = 4,
  parameter int NUM_FX  = 3,
  parameter int NUM_EVT = 8,
  parameter int CNT_W   = 48,
  parameter int ADDR_W  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_EVT-1:0]       own_evt,
  input  logic [NUM_EVT-1:0]       sib_evt,
  input  priv_t                    own_lvl,
  input  priv_t                    sib_lvl,
  input  logic [NUM_FX-1:0]        own_fix,
  input  logic [NUM_FX-1:0]        sib_fix,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [CNT_W-1:0]         wdata,
  output logic [CNT_W-1:0]         rdata,
  output logic [NUM_GP+NUM_FX-1:0] ovf_o
);
  localparam int NOVF   = NUM_GP + NUM_FX;
  localparam int A_CTR  = NUM_GP;
  localparam int A_FIX  = 2 * NUM_GP;
  localparam int A_FCTL = A_FIX + NUM_FX;
  localparam int A_OVF  = A_FCTL + 1;
  localparam int A_CLR  = A_OVF + 1;
  localparam int IDX_W  = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1;
  localparam int FCTL_W = FX_FIELD_W * NUM_FX;

  logic [SEL_W-1:0]  sel_q [NUM_GP];
  logic [FCTL_W-1:0] fctl_q;
  logic [CNT_W-1:0]  cnt_v [NOVF];
  logic [NOVF-1:0]   wrap_v;
  logic [NOVF-1:0]   clr_m;
  logic              clr_hit;

  for (genvar g = 0; g < NUM_GP; g++) begin : g_gp
    logic       code_ok;
    logic       own_raw;
    logic       sib_raw;
    logic [1:0] inc;

    assign code_ok = sel_q[g][7:0] < 8'(NUM_EVT);
    assign own_raw = code_ok & own_evt[sel_q[g][IDX_W-1:0]];
    assign sib_raw = code_ok & sib_evt[sel_q[g][IDX_W-1:0]];

    smt_pmu_gate u_gate (
      .clk(clk), .rst_n(rst_n), .own_raw(own_raw), .sib_raw(sib_raw),
      .own_lvl(own_lvl), .sib_lvl(sib_lvl),
      .os_en(sel_q[g][SEL_OS_BIT]), .usr_en(sel_q[g][SEL_USR_BIT]),
      .any_en(sel_q[g][SEL_ANY_BIT]), .cnt_en(sel_q[g][SEL_EN_BIT]),
      .inc_o(inc)
    );

    smt_pmu_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .inc(inc),
      .wr_en(wr_en && addr == ADDR_W'(A_CTR + g)), .wr_val(wdata),
      .cnt_o(cnt_v[g]), .wrap_o(wrap_v[g])
    );

    always_ff @(posedge clk) begin
      if (!rst_n)                               sel_q[g] <= '0;
      else if (wr_en && addr == ADDR_W'(g))     sel_q[g] <= wdata[SEL_W-1:0];
    end
  end

  for (genvar j = 0; j < NUM_FX; j++) begin : g_fx
    logic [FX_FIELD_W-1:0] fld;
    logic [1:0]            inc;

    assign fld = fctl_q[FX_FIELD_W*j +: FX_FIELD_W];

    smt_pmu_gate u_gate (
      .clk(clk), .rst_n(rst_n), .own_raw(own_fix[j]), .sib_raw(sib_fix[j]),
      .own_lvl(own_lvl), .sib_lvl(sib_lvl),
      .os_en(fld[FX_OS_BIT]), .usr_en(fld[FX_USR_BIT]),
      .any_en(fld[FX_ANY_BIT]), .cnt_en(1'b1),
      .inc_o(inc)
    );

    smt_pmu_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .inc(inc),
      .wr_en(wr_en && addr == ADDR_W'(A_FIX + j)), .wr_val(wdata),
      .cnt_o(cnt_v[NUM_GP+j]), .wrap_o(wrap_v[NUM_GP+j])
    );
  end

  assign clr_hit = wr_en && addr == ADDR_W'(A_CLR);
  assign clr_m   = clr_hit ? wdata[NOVF-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fctl_q <= '0;
      ovf_o  <= '0;
    end else begin
      if (wr_en && addr == ADDR_W'(A_FCTL)) fctl_q <= wdata[FCTL_W-1:0];
      ovf_o <= (ovf_o & ~clr_m) | wrap_v;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_GP; i++)
      if (addr == ADDR_W'(i)) rdata = CNT_W'(sel_q[i]);
    for (int i = 0; i < NOVF; i++)
      if (addr == ADDR_W'(A_CTR + i)) rdata = cnt_v[i];
    if (addr == ADDR_W'(A_FCTL)) rdata = CNT_W'(fctl_q);
    if (addr == ADDR_W'(A_OVF))  rdata = CNT_W'(ovf_o);
  end

  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_hit |=> (ovf_o & $past(ovf_o)) == $past(ovf_o));
  assert_wrap_sets_R10: assert property (@(posedge clk) disable iff (!rst_n)
    |wrap_v |=> (ovf_o & $past(wrap_v)) == $past(wrap_v));
endmodule

// File: rtl/smt_perf_counters.sv
module smt_perf_counters
  import smt_pmu_pkg::*;
#(
  parameter int NUM_GP  = 4,
  parameter int NUM_FX  = 3,
  parameter int NUM_EVT = 8,
  parameter int CNT_W   = 48,
  parameter int ADDR_W  = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [1:0][NUM_EVT-1:0]        evt_i,
  input  logic [1:0][1:0]                priv_i,
  input  logic [1:0][NUM_FX-1:0]         fix_i,
  input  logic                           reg_we,
  input  logic                           reg_tid,
  input  logic [ADDR_W-1:0]              reg_addr,
  input  logic [CNT_W-1:0]               reg_wdata,
  output logic [CNT_W-1:0]               reg_rdata,
  output logic [1:0][NUM_GP+NUM_FX-1:0]  ovf_o
);
  localparam int A_CLR = 2 * NUM_GP + NUM_FX + 2;

  logic [CNT_W-1:0] rd_v [2];

  for (genvar t = 0; t < 2; t++) begin : g_thr
    smt_pmu_thread_regs #(
      .NUM_GP(NUM_GP), .NUM_FX(NUM_FX), .NUM_EVT(NUM_EVT),
      .CNT_W(CNT_W), .ADDR_W(ADDR_W)
    ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .own_evt(evt_i[t]), .sib_evt(evt_i[1-t]),
      .own_lvl(priv_i[t]), .sib_lvl(priv_i[1-t]),
      .own_fix(fix_i[t]), .sib_fix(fix_i[1-t]),
      .wr_en(reg_we && reg_tid == 1'(t)),
      .addr(reg_addr), .wdata(reg_wdata),
      .rdata(rd_v[t]), .ovf_o(ovf_o[t])
    );
  end

  assign reg_rdata = rd_v[reg_tid];

  assert_clear_isolated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == ADDR_W'(A_CLR))
      |=> (ovf_o[!$past(reg_tid)] & $past(ovf_o[!reg_tid])) == $past(ovf_o[!reg_tid]));
endmodule

// File: tb/smt_perf_counters_tb.sv
`timescale 1ns/1ps
module smt_perf_counters_tb;
  localparam int NG = 4, NF = 3, NE = 8, CW = 48, AW = 4, NO = 7;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic                 rst_n;
  logic [1:0][NE-1:0]   evt, s_evt;
  logic [1:0][1:0]      priv, s_priv;
  logic [1:0][NF-1:0]   fix, s_fix;
  logic                 we, s_we, tid, s_tid;
  logic [AW-1:0]        addr, s_addr;
  logic [CW-1:0]        wdata, s_wdata, rdata;
  logic [1:0][NO-1:0]   ovf;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  logic [CW-1:0] m_ctr [2][NO];
  logic [31:0]   m_sel [2][NG];
  logic [11:0]   m_fctl[2];
  logic [NO-1:0] m_ovf [2];

  smt_perf_counters u_dut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .priv_i(priv), .fix_i(fix),
    .reg_we(we), .reg_tid(tid), .reg_addr(addr), .reg_wdata(wdata),
    .reg_rdata(rdata), .ovf_o(ovf)
  );

  function automatic bit lvl_ok(input logic [1:0] lvl, input logic os, input logic usr);
    if (lvl == 2'd0) return os;
    return usr;
  endfunction

  // number of contributing threads for counter k of thread t this cycle
  function automatic int hits(input int t, input int k);
    int n = 0;
    for (int th = 0; th < 2; th++) begin
      bit src, os, usr, any;
      if (k < NG) begin
        logic [31:0] s = m_sel[t][k];
        src = s[22] && (s[7:0] < 8'd8) && evt[th][s[2:0]];
        os = s[17]; usr = s[16]; any = s[21];
      end else begin
        logic [3:0] f = m_fctl[t][4*(k-NG) +: 4];
        src = fix[th][k-NG];
        os = f[0]; usr = f[1]; any = f[2];
      end
      if (th != t && !any) src = 1'b0;
      if (src && lvl_ok(priv[th], os, usr)) n++;
    end
    return n;
  endfunction

  task automatic model_tick();
    logic [NO-1:0] wr [2];
    for (int t = 0; t < 2; t++) begin
      wr[t] = '0;
      for (int k = 0; k < NO; k++) begin
        logic [CW:0] s = {1'b0, m_ctr[t][k]} + (CW+1)'(hits(t, k));
        if (we && tid == 1'(t) && addr == AW'(4 + k)) m_ctr[t][k] = wdata;
        else begin
          m_ctr[t][k] = s[CW-1:0];
          wr[t][k] = s[CW];
        end
      end
    end
    for (int t = 0; t < 2; t++) begin
      if (we && tid == 1'(t) && addr == AW'(13)) m_ovf[t] = m_ovf[t] & ~wdata[NO-1:0];
      m_ovf[t] = m_ovf[t] | wr[t];
    end
    if (we && addr < AW'(4)) m_sel[tid][addr[1:0]] = wdata[31:0];
    if (we && addr == AW'(11)) m_fctl[tid] = wdata[11:0];
  endtask

  function automatic logic [CW-1:0] exp_rd(input int t, input int a);
    if (a < 4)  return CW'(m_sel[t][a]);
    if (a < 11) return m_ctr[t][a-4];
    if (a == 11) return CW'(m_fctl[t]);
    if (a == 12) return CW'(m_ovf[t]);
    return '0;
  endfunction

  task automatic chk(input string req, input string what, input logic [CW-1:0] got, input logic [CW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    evt = s_evt; priv = s_priv; fix = s_fix;
    we = s_we; tid = s_tid; addr = s_addr; wdata = s_wdata;
    @(posedge clk);
    model_tick();
  endtask

  task automatic wr_cyc(input logic t, input int a, input logic [CW-1:0] d);
    s_we = 1'b1; s_tid = t; s_addr = AW'(a); s_wdata = d;
    cyc();
    s_we = 1'b0;
  endtask

  task automatic quiet();
    s_evt = '0; s_fix = '0; s_priv = '0; s_we = 1'b0;
  endtask

  task automatic rd_chk(input logic t, input int a, input logic [CW-1:0] exp, input string req);
    @(negedge clk);
    evt = '0; fix = '0; we = 1'b0; tid = t; addr = AW'(a);
    #2;
    chk(req, $sformatf("t%0d addr %0d", t, a), rdata, exp);
  endtask

  task automatic read_all(input string req);
    for (int t = 0; t < 2; t++) begin
      for (int a = 0; a < 16; a++) rd_chk(1'(t), a, exp_rd(t, a), req);
      chk(req, $sformatf("ovf_o t%0d", t), CW'(ovf[t]), CW'(m_ovf[t]));
    end
  endtask

  initial begin
    #4000000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int t = 0; t < 2; t++) begin
      for (int k = 0; k < NO; k++) m_ctr[t][k] = '0;
      for (int k = 0; k < NG; k++) m_sel[t][k] = '0;
      m_fctl[t] = '0; m_ovf[t] = '0;
    end
    evt = '0; priv = '0; fix = '0; we = 1'b0; tid = 1'b0; addr = '0; wdata = '0;
    quiet(); s_tid = 1'b0; s_addr = '0; s_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    read_all("R1");

    // own-thread, cross-thread and per-thread privilege
    wr_cyc(1'b0, 0, 48'h0000_0043_0003);
    wr_cyc(1'b1, 0, 48'h0000_0061_0005);
    s_evt[0] = 8'h08; s_evt[1] = 8'h28; s_priv[0] = 2'd0; s_priv[1] = 2'd3; cyc();
    quiet();
    rd_chk(1'b0, 4, 48'd1, "R2");
    rd_chk(1'b1, 4, 48'd1, "R2");
    s_evt[0] = 8'h20; s_evt[1] = 8'h20; s_priv[0] = 2'd3; s_priv[1] = 2'd3; cyc();
    quiet();
    rd_chk(1'b1, 4, 48'd3, "R3");
    rd_chk(1'b0, 4, 48'd1, "R2");
    s_evt[0] = 8'h20; s_evt[1] = 8'h20; s_priv[0] = 2'd0; s_priv[1] = 2'd3; cyc();
    quiet();
    rd_chk(1'b1, 4, 48'd4, "R4");

    // disabled counter and out-of-range event code
    wr_cyc(1'b0, 1, 48'h0000_0003_0003);
    wr_cyc(1'b0, 2, 48'h0000_0043_0009);
    s_evt = '1; cyc(); quiet();
    rd_chk(1'b0, 5, 48'd0, "R5");
    rd_chk(1'b0, 6, 48'd0, "R5");
    rd_chk(1'b0, 4, 48'd2, "R2");

    // thread isolation of the register port
    wr_cyc(1'b1, 4, 48'd100);
    rd_chk(1'b0, 4, 48'd2, "R6");
    rd_chk(1'b1, 4, 48'd100, "R6");

    // fixed counters
    wr_cyc(1'b0, 11, 48'h863);
    s_fix[0] = 3'b111; s_fix[1] = 3'b111; s_priv[0] = 2'd0; s_priv[1] = 2'd2; cyc(); quiet();
    rd_chk(1'b0, 8, 48'd1, "R7");
    rd_chk(1'b0, 9, 48'd1, "R7");
    rd_chk(1'b0, 10, 48'd0, "R7");
    rd_chk(1'b0, 11, 48'h863, "R7");

    // write beats increment
    s_evt[0] = 8'h08; s_priv[0] = 2'd0; s_we = 1'b1; s_tid = 1'b0; s_addr = 4'd4; s_wdata = 48'h55;
    cyc(); quiet();
    rd_chk(1'b0, 4, 48'h55, "R8");

    // wrap and sticky flag
    wr_cyc(1'b1, 2, 48'h0000_0043_0000);
    wr_cyc(1'b1, 6, '1);
    s_evt[1] = 8'h01; s_priv[1] = 2'd0; cyc(); quiet();
    rd_chk(1'b1, 6, 48'd0, "R9");
    chk("R9", "ovf_o t1", CW'(ovf[1]), 48'h04);
    chk("R9", "ovf_o t0", CW'(ovf[0]), 48'h00);
    cyc();
    rd_chk(1'b1, 12, 48'h04, "R9");
    wr_cyc(1'b1, 4, 48'hFFFF_FFFF_FFFE);
    s_evt[0] = 8'h20; s_evt[1] = 8'h20; s_priv[0] = 2'd1; s_priv[1] = 2'd1; cyc(); quiet();
    rd_chk(1'b1, 4, 48'd0, "R3");
    rd_chk(1'b1, 12, 48'h05, "R9");

    // clear: per thread, and wrap beats clear
    wr_cyc(1'b0, 13, 48'h7F);
    rd_chk(1'b1, 12, 48'h05, "R10");
    wr_cyc(1'b1, 13, 48'h01);
    rd_chk(1'b1, 12, 48'h04, "R10");
    wr_cyc(1'b1, 6, '1);
    s_evt[1] = 8'h01; s_priv[1] = 2'd0; s_we = 1'b1; s_tid = 1'b1; s_addr = 4'd13; s_wdata = 48'h04;
    cyc(); quiet();
    rd_chk(1'b1, 12, 48'h04, "R10");

    // read map corners
    wr_cyc(1'b0, 3, '1);
    rd_chk(1'b0, 3, 48'h0000_FFFF_FFFF, "R11");
    rd_chk(1'b0, 13, 48'd0, "R11");
    rd_chk(1'b1, 15, 48'd0, "R11");
    read_all("R11");

    // random rounds against the model
    for (int r = 0; r < 4; r++) begin
      for (int t = 0; t < 2; t++) begin
        for (int g = 0; g < NG; g++) begin
          logic [31:0] v = $urandom;
          v[7:0] = 8'($urandom_range(0, 9));
          wr_cyc(1'(t), g, CW'(v));
        end
        wr_cyc(1'(t), 11, CW'($urandom));
      end
      for (int c = 0; c < 400; c++) begin
        s_evt = 16'($urandom); s_fix = 6'($urandom); s_priv = 4'($urandom);
        s_we = ($urandom_range(0, 15) == 0);
        s_tid = 1'($urandom);
        s_addr = AW'($urandom_range(4, 13));
        if ($urandom_range(0, 1) == 0) s_wdata = 48'hFFFF_FFFF_FFF0 | CW'($urandom_range(0, 15));
        else s_wdata = {16'($urandom), 32'($urandom)};
        if (s_addr == AW'(11) || s_addr == AW'(12)) s_we = 1'b0;
        cyc();
      end
      quiet();
      read_all("R2,R3,R4,R7,R9,R10");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule